// File: doc/BRIEF.md
# Overvoltage Fault Supervisor

This block watches a comparator flag that goes high when the regulator's feedback rises above the overvoltage threshold, which sits at about 120% of the reference. When that flag stays high for longer than one switching cycle, the block declares an overvoltage fault. While the fault lasts, it asks the clock generator for the fixed 50 kHz discharge frequency. It also takes over the four switches of the buck-boost bridge. The input-side high switch S1 is held off and the input-side low switch S2 is held on. The output-side pair S3 and S4 is alternated to drain the output, and the negative-current-limit flag steers this pair so that reverse inductor current stays within its limit.

Detection is blanked while the output voltage is being moved. An arming state machine has three states. In BLANKED it waits for the soft-start-done pulse. In HOLDOFF it counts `HOLD_US` microsecond ticks, 1 ms by default. In ARMED detection is live. The transitions are: BLANKED to HOLDOFF on soft-start done with no slewing; HOLDOFF to ARMED on the last tick of the count; HOLDOFF or ARMED back to BLANKED whenever slewing is high. A detection state machine has four states: IDLE, QUALIFY, FAULT and RELEASE. The transitions are: IDLE to QUALIFY when armed with the flag high; QUALIFY back to IDLE when the flag drops or arming is lost; QUALIFY to FAULT on the second switching tick with the flag high; FAULT to RELEASE when the flag drops; RELEASE back to FAULT when the flag rises; RELEASE to IDLE on the second switching tick with the flag low. The mask bit suppresses both the fault indication and the discharge action, but qualification continues underneath it.

Top module: `ov_supervisor`

## Requirements
- R1: After reset, or after a reset applied in the middle of a fault, all outputs are 0 and detection stays blanked until a soft-start-done pulse arrives, even while the comparator flag is high and ticks keep arriving.
- R2: After soft-start done, detection turns on only after `HOLD_US` microsecond ticks. With one tick fewer, a sustained over-threshold condition raises no fault. The comparator is ignored during the hold-off.
- R3: Slewing high in any arming state returns to BLANKED, which restarts the hold-off. A soft-start-done pulse that arrives while slewing is high is ignored.
- R4: With detection live, the fault sets on the second switching tick after the comparator flag rose, provided the flag stayed high. If the flag drops before then, qualification restarts from zero.
- R5: An active fault clears on the second switching tick after the flag fell, provided the flag stayed low. If the flag rises again before that tick, including in the same cycle as a tick, the fault holds and the release count restarts.
- R6: While the discharge is active, the outputs are: `sw_own`=1, `s1_on`=0, `s2_on`=1, and exactly one of `s3_on`/`s4_on` high. The pattern starts with `s4_on` and swaps on every switching tick.
- R7: While the discharge is active, `neg_ilim`=1 forces `s3_on`=1 and `s4_on`=0 in the same cycle.
- R8: `lowfreq_sel` is 1 exactly while the unmasked fault is active, and it returns to 0 when the fault clears.
- R9: With `ov_mask`=1, `ov_fault`, `lowfreq_sel`, `sw_own` and all switch outputs are 0. A fault qualified under the mask appears as soon as the mask drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_cmp | input | 1 | Feedback above overvoltage threshold |
| cyc_tick | input | 1 | One-cycle pulse per switching period |
| slewing | input | 1 | Output voltage is being changed |
| ss_done | input | 1 | Soft-start completion pulse |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ov_mask | input | 1 | 1 suppresses fault action and indication |
| neg_ilim | input | 1 | Inductor current at the negative limit |
| ov_fault | output | 1 | Unmasked overvoltage fault indication |
| lowfreq_sel | output | 1 | Select the fixed 50 kHz discharge clock |
| sw_own | output | 1 | Supervisor drives the switches (PWM otherwise) |
| s1_on | output | 1 | Input high-side switch command |
| s2_on | output | 1 | Input low-side switch command |
| s3_on | output | 1 | Output high-side switch command |
| s4_on | output | 1 | Output low-side switch command |

## Verification
Two events can land in the same cycle. The first pair is a switching tick that swaps the S3/S4 phase and a negative-current-limit flag that overrides that phase. The bench drives both in one vector and expects S3 on with S4 off, after which the pattern resumes from the swapped phase. The second pair is a release-count tick and a re-rise of the comparator flag. The bench drives both together in the RELEASE state and expects the fault to hold with the discharge phase still swapped, so that clearing needs two fresh low ticks afterwards.

// File: rtl/ov_sup_pkg.sv
package ov_sup_pkg;

    typedef enum logic [1:0] {
        ARM_BLANK = 2'd0,
        ARM_HOLD  = 2'd1,
        ARM_LIVE  = 2'd2
    } arm_state_t;

    typedef enum logic [1:0] {
        DET_IDLE    = 2'd0,
        DET_QUALIFY = 2'd1,
        DET_FAULT   = 2'd2,
        DET_RELEASE = 2'd3
    } det_state_t;

endpackage

// File: rtl/ov_arm_ctrl.sv
module ov_arm_ctrl #(
    parameter int HOLD_US = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slewing,
    input  logic ss_done,
    input  logic us_tick,
    output logic armed
);
    import ov_sup_pkg::*;

    localparam int CW = $clog2(HOLD_US + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_US - 1);

    arm_state_t    state, state_n;
    logic [CW-1:0] cnt;

    always_comb begin
        state_n = state;
        unique case (state)
            ARM_BLANK: begin
                if (!slewing && ss_done)
                    state_n = ARM_HOLD;
            end
            ARM_HOLD: begin
                if (slewing)
                    state_n = ARM_BLANK;
                else if (us_tick && cnt == LAST)
                    state_n = ARM_LIVE;
            end
            ARM_LIVE: begin
                if (slewing)
                    state_n = ARM_BLANK;
            end
            default: state_n = ARM_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ARM_BLANK;
            cnt   <= '0;
        end else begin
            state <= state_n;
            if (state_n != ARM_HOLD || state != ARM_HOLD)
                cnt <= '0;
            else if (us_tick)
                cnt <= cnt + CW'(1);
        end
    end

    always_comb begin
        armed = (state == ARM_LIVE);
    end

    // R2
    arm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(us_tick) && !$past(slewing));

    // R3
    slew_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slewing |=> !armed);

endmodule

// File: rtl/ov_detect.sv
module ov_detect #(
    parameter int QUAL_TICKS  = 2,
    parameter int CLEAR_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic ov_cmp,
    input  logic cyc_tick,
    output logic fault_active
);
    import ov_sup_pkg::*;

    localparam int TMAX = (QUAL_TICKS > CLEAR_TICKS) ? QUAL_TICKS : CLEAR_TICKS;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] QLAST = CW'(QUAL_TICKS - 1);
    localparam logic [CW-1:0] CLAST = CW'(CLEAR_TICKS - 1);

    det_state_t    state, state_n;
    logic [CW-1:0] cnt;
    logic          counting;

    always_comb begin
        state_n = state;
        unique case (state)
            DET_IDLE: begin
                if (armed && ov_cmp)
                    state_n = DET_QUALIFY;
            end
            DET_QUALIFY: begin
                if (!ov_cmp || !armed)
                    state_n = DET_IDLE;
                else if (cyc_tick && cnt == QLAST)
                    state_n = DET_FAULT;
            end
            DET_FAULT: begin
                if (!ov_cmp)
                    state_n = DET_RELEASE;
            end
            DET_RELEASE: begin
                if (ov_cmp)
                    state_n = DET_FAULT;
                else if (cyc_tick && cnt == CLAST)
                    state_n = DET_IDLE;
            end
            default: state_n = DET_IDLE;
        endcase
    end

    always_comb begin
        counting = (state == DET_QUALIFY) || (state == DET_RELEASE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DET_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            if (state_n != state)
                cnt <= '0;
            else if (counting && cyc_tick)
                cnt <= cnt + CW'(1);
        end
    end

    always_comb begin
        fault_active = (state == DET_FAULT) || (state == DET_RELEASE);
    end

    // R4
    fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_active) |-> $past(cyc_tick) && $past(ov_cmp));

    // R5
    fault_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_active) |-> $past(cyc_tick) && !$past(ov_cmp));

endmodule

// File: rtl/ov_discharge.sv
module ov_discharge (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic cyc_tick,
    input  logic neg_ilim,
    output logic sw_own,
    output logic s1_on,
    output logic s2_on,
    output logic s3_on,
    output logic s4_on
);
    logic phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= 1'b0;
        else if (!active)
            phase <= 1'b0;
        else if (cyc_tick)
            phase <= ~phase;
    end

    always_comb begin
        sw_own = active;
        s1_on  = 1'b0;
        s2_on  = active;
        s3_on  = active && (phase || neg_ilim);
        s4_on  = active && !phase && !neg_ilim;
    end

    // R6
    pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> s2_on && !s1_on && $onehot({s3_on, s4_on}));

    // R7
    ilim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && neg_ilim) |-> s3_on && !s4_on);

endmodule

// File: rtl/ov_supervisor.sv
module ov_supervisor #(
    parameter int HOLD_US     = 1000,
    parameter int QUAL_TICKS  = 2,
    parameter int CLEAR_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ov_cmp,
    input  logic cyc_tick,
    input  logic slewing,
    input  logic ss_done,
    input  logic us_tick,
    input  logic ov_mask,
    input  logic neg_ilim,
    output logic ov_fault,
    output logic lowfreq_sel,
    output logic sw_own,
    output logic s1_on,
    output logic s2_on,
    output logic s3_on,
    output logic s4_on
);
    logic armed;
    logic fault_active;
    logic act;

    ov_arm_ctrl #(.HOLD_US(HOLD_US)) u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .slewing (slewing),
        .ss_done (ss_done),
        .us_tick (us_tick),
        .armed   (armed)
    );

    ov_detect #(.QUAL_TICKS(QUAL_TICKS), .CLEAR_TICKS(CLEAR_TICKS)) u_det (
        .clk          (clk),
        .rst_n        (rst_n),
        .armed        (armed),
        .ov_cmp       (ov_cmp),
        .cyc_tick     (cyc_tick),
        .fault_active (fault_active)
    );

    always_comb begin
        act         = fault_active && !ov_mask;
        ov_fault    = act;
        lowfreq_sel = act;
    end

    ov_discharge u_dis (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (act),
        .cyc_tick (cyc_tick),
        .neg_ilim (neg_ilim),
        .sw_own   (sw_own),
        .s1_on    (s1_on),
        .s2_on    (s2_on),
        .s3_on    (s3_on),
        .s4_on    (s4_on)
    );

    // R9
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_mask |-> !lowfreq_sel && !sw_own && !s2_on && !s3_on && !s4_on);

    // R8
    lowfreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lowfreq_sel |-> sw_own && s2_on);

endmodule

// File: tb/ov_supervisor_tb.sv
`timescale 1ns/1ps
module ov_supervisor_tb;

    localparam int HOLD = 4;
    localparam int NV   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ov_cmp = 0, cyc_tick = 0, slewing = 0, ss_done = 0;
    logic us_tick = 0, ov_mask = 0, neg_ilim = 0;
    logic ov_fault, lowfreq_sel, sw_own, s1_on, s2_on, s3_on, s4_on;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ov_supervisor #(.HOLD_US(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .ov_cmp(ov_cmp), .cyc_tick(cyc_tick),
        .slewing(slewing), .ss_done(ss_done), .us_tick(us_tick),
        .ov_mask(ov_mask), .neg_ilim(neg_ilim), .ov_fault(ov_fault),
        .lowfreq_sel(lowfreq_sel), .sw_own(sw_own), .s1_on(s1_on),
        .s2_on(s2_on), .s3_on(s3_on), .s4_on(s4_on)
    );

    // input bits {cmp,tick,slew,ssd,ust,mask,nil}
    localparam logic [6:0] I_CMP  = 7'b1000000;
    localparam logic [6:0] I_TICK = 7'b0100000;
    localparam logic [6:0] I_SLEW = 7'b0010000;
    localparam logic [6:0] I_SSD  = 7'b0001000;
    localparam logic [6:0] I_UST  = 7'b0000100;
    localparam logic [6:0] I_MASK = 7'b0000010;
    // expected bits {fault,lowfreq,s2,s3,s4}; sw_own follows fault, s1 is 0
    localparam logic [4:0] E_OFF = 5'b00000;
    localparam logic [4:0] E_S4  = 5'b11101;
    localparam logic [4:0] E_S3  = 5'b11110;

    // {req[3:0], inputs[6:0], expected[4:0]}
    localparam logic [15:0] VEC [NV] = '{
        {4'd2, 7'b0001000, E_OFF},
        {4'd2, 7'b0000100, E_OFF},
        {4'd2, 7'b1100100, E_OFF},
        {4'd2, 7'b0000100, E_OFF},
        {4'd2, 7'b1000100, E_OFF},
        {4'd4, 7'b1000000, E_OFF},
        {4'd4, 7'b1100000, E_OFF},
        {4'd4, 7'b1000000, E_OFF},
        {4'd4, 7'b1100000, E_S4},
        {4'd6, 7'b1100000, E_S3},
        {4'd7, 7'b1100001, E_S3},
        {4'd8, 7'b1000000, E_S4},
        {4'd9, 7'b1000010, E_OFF},
        {4'd5, 7'b0000000, E_S4},
        {4'd5, 7'b0100000, E_S3},
        {4'd5, 7'b1100000, E_S4},
        {4'd5, 7'b0000000, E_S4},
        {4'd5, 7'b0100000, E_S3},
        {4'd8, 7'b0100000, E_OFF},
        {4'd5, 7'b0000000, E_OFF}
    };

    task automatic cyc(input logic [6:0] v);
        {ov_cmp, cyc_tick, slewing, ss_done, us_tick, ov_mask, neg_ilim} = v;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [4:0] e);
        logic [6:0] act, exp;
        act = {ov_fault, lowfreq_sel, sw_own, s1_on, s2_on, s3_on, s4_on};
        exp = {e[4], e[3], e[4], 1'b0, e[2], e[1], e[0]};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic try_qual(input logic [6:0] extra);
        cyc(I_CMP | extra);
        cyc(I_CMP | I_TICK | extra);
        cyc(I_CMP | I_TICK | extra);
    endtask

    task automatic clear_fault();
        cyc(7'b0);
        cyc(I_TICK);
        cyc(I_TICK);
        chk("R5", E_OFF);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired, actual hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and blanking before soft start
        chk("R1", E_OFF);
        try_qual(7'b0);
        chk("R1", E_OFF);
        cyc(7'b0);

        for (int i = 0; i < NV; i++) begin
            logic [4:0] e;
            cyc(VEC[i][11:5]);
            e = VEC[i][4:0];
            checks++;
            if ({ov_fault, lowfreq_sel, sw_own, s1_on, s2_on, s3_on, s4_on}
                !== {e[4], e[3], e[4], 1'b0, e[2], e[1], e[0]}) begin
                errors++;
                $display("FAIL R%0d row %0d actual %b expected %b", VEC[i][15:12], i,
                         {ov_fault, lowfreq_sel, sw_own, s1_on, s2_on, s3_on, s4_on},
                         {e[4], e[3], e[4], 1'b0, e[2], e[1], e[0]});
            end
        end

        // R4 drop before second tick restarts qualification
        cyc(I_CMP);
        cyc(I_CMP | I_TICK);
        cyc(7'b0);
        cyc(I_CMP);
        cyc(I_CMP | I_TICK);
        chk("R4", E_OFF);
        cyc(I_CMP | I_TICK);
        chk("R4", E_S4);
        clear_fault();

        // R3 slewing blanks detection
        cyc(I_SLEW);
        try_qual(7'b0);
        chk("R3", E_OFF);
        cyc(7'b0);
        // R3 soft-start done during slewing is ignored
        cyc(I_SLEW | I_SSD);
        cyc(7'b0);
        for (int k = 0; k < HOLD; k++) cyc(I_UST);
        try_qual(7'b0);
        chk("R3", E_OFF);
        cyc(7'b0);

        // R3 slewing restarts hold-off; R2 one tick short stays blanked
        cyc(I_SSD);
        for (int k = 0; k < HOLD - 1; k++) cyc(I_UST);
        cyc(I_SLEW);
        cyc(I_SSD);
        for (int k = 0; k < HOLD - 1; k++) cyc(I_UST);
        try_qual(7'b0);
        chk("R2", E_OFF);
        cyc(7'b0);
        cyc(I_UST);
        try_qual(7'b0);
        chk("R2", E_S4);
        clear_fault();

        // R9 qualification continues under mask
        try_qual(I_MASK);
        chk("R9", E_OFF);
        cyc(I_CMP);
        chk("R9", E_S4);
        clear_fault();

        // R1 reset in the middle of a fault
        try_qual(7'b0);
        chk("R4", E_S4);
        rst_n = 1'b0;
        cyc(7'b0);
        chk("R1", E_OFF);
        rst_n = 1'b1;
        cyc(7'b0);
        for (int k = 0; k < HOLD; k++) cyc(I_UST);
        try_qual(7'b0);
        chk("R1", E_OFF);
        cyc(7'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule